// File: doc/BRIEF.md
# Staged power-switch clamp sequencer

This block drives the 8-bit clamp control word of the power switch for one CPU core domain. A zero bit in the word means that slice of the switch conducts. To keep inrush current low, the block turns the switch on through a fixed ladder of partial codes. It holds each code for a set number of microsecond ticks before it moves to the next one. When it turns the switch off, all slices open at once. In both directions the block then waits until an 8-bit readback of the switch state confirms the final word.

Control logic raises a one-cycle enable or disable request. The block signals `busy_o` while a sequence runs and pulses `done_o` when the sequence ends. If the readback never confirms, a tick-based timeout raises `err_o` and the block returns to idle. When the readback already shows the requested final state, the block completes the request without writing the clamp word. A build parameter can drop one intermediate rung from the ladder.

Top module: `pwr_clamp_seq`

## Requirements
- R1: During and after reset the clamp word is 0xFF (switch fully open), and `busy_o`, `done_o` and `err_o` are low.
- R2: An accepted enable request writes the clamp codes 0xFE, 0xF8, 0xE0, 0xC0, 0x80 and 0x00, in that order. The first code appears in the cycle after the request edge, and no other value is written.
- R3: Each code stays on the output for a fixed number of ticks: 20 ticks for 0xFE and 10 ticks each for 0xF8, 0xE0, 0xC0 and 0x80. A code changes only on a clock edge at which the tick input is high.
- R4: After 0x00 is written, 20 ticks pass. The block then waits until the readback equals 0x00 and ends with a `done_o` pulse that lasts exactly one cycle. `busy_o` is high from the cycle after acceptance until the cycle in which `done_o` is high, and low in that cycle.
- R5: If the readback equals 0x00 when an enable request is accepted, the clamp word does not change, `busy_o` stays low and `done_o` pulses in the next cycle.
- R6: An accepted disable request writes 0xFF in the next cycle and makes no further writes. After 30 ticks the block waits for the readback to equal 0xFF, then pulses `done_o`.
- R7: If the readback equals 0xFF when a disable request is accepted, the clamp word does not change, `busy_o` stays low and `done_o` pulses in the next cycle.
- R8: Requests that arrive while `busy_o` is high have no effect on the code sequence or its timing. When enable and disable are requested in the same idle cycle, the block carries out the enable.
- R9: If the readback does not match within the timeout (100 ticks by default, counted from the start of the readback wait), `err_o` rises. On that same edge `busy_o` falls, no `done_o` pulse is given and the clamp word keeps its last value. `err_o` stays high until the next request is accepted.
- R10: With the intermediate rung removed by parameter, the enable ladder is 0xFE, 0xF8, 0xE0, 0x80, 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req_i | input | 1 | Request to close the switch (staged) |
| dis_req_i | input | 1 | Request to open the switch |
| tick_i | input | 1 | One-cycle pulse per microsecond |
| rb_i | input | 8 | Readback of the switch state |
| clamp_o | output | 8 | Clamp control word, 0xFF fully open |
| busy_o | output | 1 | A sequence is running |
| done_o | output | 1 | One-cycle pulse when a sequence or skip completes |
| err_o | output | 1 | Readback wait timed out |

## Verification
Each timed result has a fixed place relative to the request edge or to a tick edge:
- the first clamp code, or a skip's `done_o` pulse, appears in the cycle after the request edge;
- each later code appears on the tick edge that completes its dwell;
- `done_o` comes one cycle after the last tick of the final dwell, provided the readback already matches;
- `err_o` rises on the tick edge that exhausts the timeout.

The bench drives inputs and samples outputs 5 ns after each rising edge. It counts only the ticks that were high at the edges since the last code change, so each dwell is checked as an exact tick count, not by wall-clock cycles. Requests injected while the block is busy are held for a single edge. The bench stops injecting once `busy_o` has fallen, so an injected request is never accepted.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  localparam int CLAMP_W = 8;
  typedef logic [CLAMP_W-1:0] clamp_t;

  localparam clamp_t CLAMP_OPEN   = '1;
  localparam clamp_t CLAMP_CLOSED = '0;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RAMP,
    ST_OFFDW,
    ST_WAIT
  } seq_state_e;

  // number of low bits cleared on each rung of the full six-rung ladder
  function automatic int cleared_bits(input int rung);
    case (rung)
      0:       return 1;
      1:       return 3;
      2:       return 5;
      3:       return 6;
      4:       return 7;
      default: return CLAMP_W;
    endcase
  endfunction

  function automatic clamp_t rung_code(input int rung);
    return CLAMP_OPEN << cleared_bits(rung);
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pcs_ladder.sv
module pcs_ladder
  import pcs_pkg::*;
#(
  parameter bit USE_MID_STEP = 1'b1,
  parameter int IDX_W        = 3,
  parameter int CNT_W        = 7,
  parameter int DWELL_FIRST  = 20,
  parameter int DWELL_MID    = 10,
  parameter int DWELL_LAST   = 20
) (
  input  logic [IDX_W-1:0] idx_i,
  output clamp_t           code_cur_o,
  output clamp_t           code_nxt_o,
  output logic [CNT_W-1:0] dwell_o,
  output logic             last_o
);

  localparam int STEPS = USE_MID_STEP ? 6 : 5;

  logic [IDX_W-1:0] idx_nxt;
  logic [IDX_W-1:0] rung_cur;
  logic [IDX_W-1:0] rung_nxt;

  assign idx_nxt = idx_i + IDX_W'(1);

  generate
    if (USE_MID_STEP) begin : g_full
      assign rung_cur = idx_i;
      assign rung_nxt = idx_nxt;
    end else begin : g_short
      // skip the rung that clears six bits
      assign rung_cur = (idx_i   >= IDX_W'(3)) ? idx_i   + IDX_W'(1) : idx_i;
      assign rung_nxt = (idx_nxt >= IDX_W'(3)) ? idx_nxt + IDX_W'(1) : idx_nxt;
    end
  endgenerate

  assign code_cur_o = rung_code(int'(rung_cur));
  assign code_nxt_o = rung_code(int'(rung_nxt));
  assign last_o     = (idx_i == IDX_W'(STEPS - 1));

  always_comb begin
    if (idx_i == '0)  dwell_o = CNT_W'(DWELL_FIRST);
    else if (last_o)  dwell_o = CNT_W'(DWELL_LAST);
    else              dwell_o = CNT_W'(DWELL_MID);
  end

endmodule

// File: rtl/pcs_tick_counter.sv
module pcs_tick_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             hit_o
);

  logic [CNT_W-1:0] cnt_q;

  assign hit_o = run_i && tick_i && (cnt_q == limit_i - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clear_i)          cnt_q <= '0;
    else if (run_i && tick_i)  cnt_q <= cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/pwr_clamp_seq.sv
module pwr_clamp_seq
  import pcs_pkg::*;
#(
  parameter bit USE_MID_STEP  = 1'b1,
  parameter int DWELL_FIRST_US = 20,
  parameter int DWELL_MID_US   = 10,
  parameter int DWELL_LAST_US  = 20,
  parameter int OFF_DWELL_US   = 30,
  parameter int TIMEOUT_US     = 100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_req_i,
  input  logic         dis_req_i,
  input  logic         tick_i,
  input  logic [7:0]   rb_i,
  output logic [7:0]   clamp_o,
  output logic         busy_o,
  output logic         done_o,
  output logic         err_o
);

  localparam int IDX_W   = 3;
  localparam int LIM_MAX = max_of(max_of(DWELL_FIRST_US, DWELL_MID_US),
                                  max_of(max_of(DWELL_LAST_US, OFF_DWELL_US), TIMEOUT_US));
  localparam int CNT_W   = $clog2(LIM_MAX + 1);

  seq_state_e       state_q;
  clamp_t           clamp_q;
  clamp_t           target_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;
  logic             err_q;

  clamp_t           code_cur;
  clamp_t           code_nxt;
  logic [CNT_W-1:0] dwell_cur;
  logic             last_cur;
  logic [CNT_W-1:0] limit;
  logic             cnt_hit;

  // named internal events
  logic idle_w;
  logic accept_en_w;
  logic accept_dis_w;
  logic accept_w;
  logic skip_w;
  logic match_w;
  logic step_hit_w;
  logic timeout_w;

  assign idle_w       = (state_q == ST_IDLE);
  assign accept_en_w  = idle_w && en_req_i;
  assign accept_dis_w = idle_w && !en_req_i && dis_req_i;
  assign accept_w     = accept_en_w || accept_dis_w;
  assign skip_w       = (accept_en_w && rb_i == CLAMP_CLOSED) ||
                        (accept_dis_w && rb_i == CLAMP_OPEN);
  assign match_w      = (state_q == ST_WAIT) && (rb_i == target_q);
  assign step_hit_w   = cnt_hit && (state_q == ST_RAMP || state_q == ST_OFFDW);
  assign timeout_w    = cnt_hit && (state_q == ST_WAIT) && !match_w;

  pcs_ladder #(
    .USE_MID_STEP (USE_MID_STEP),
    .IDX_W        (IDX_W),
    .CNT_W        (CNT_W),
    .DWELL_FIRST  (DWELL_FIRST_US),
    .DWELL_MID    (DWELL_MID_US),
    .DWELL_LAST   (DWELL_LAST_US)
  ) u_ladder (
    .idx_i      (idx_q),
    .code_cur_o (code_cur),
    .code_nxt_o (code_nxt),
    .dwell_o    (dwell_cur),
    .last_o     (last_cur)
  );

  always_comb begin
    case (state_q)
      ST_RAMP:  limit = dwell_cur;
      ST_OFFDW: limit = CNT_W'(OFF_DWELL_US);
      default:  limit = CNT_W'(TIMEOUT_US);
    endcase
  end

  pcs_tick_counter #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (accept_w || cnt_hit),
    .run_i   (!idle_w),
    .tick_i  (tick_i),
    .limit_i (limit),
    .hit_o   (cnt_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      clamp_q  <= CLAMP_OPEN;
      target_q <= CLAMP_OPEN;
      idx_q    <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept_w) begin
            err_q <= 1'b0;
            idx_q <= '0;
            if (skip_w) begin
              done_q <= 1'b1;
            end else if (accept_en_w) begin
              clamp_q  <= code_cur;
              target_q <= CLAMP_CLOSED;
              state_q  <= ST_RAMP;
            end else begin
              clamp_q  <= CLAMP_OPEN;
              target_q <= CLAMP_OPEN;
              state_q  <= ST_OFFDW;
            end
          end
        end
        ST_RAMP: begin
          if (step_hit_w) begin
            if (last_cur) begin
              state_q <= ST_WAIT;
            end else begin
              idx_q   <= idx_q + IDX_W'(1);
              clamp_q <= code_nxt;
            end
          end
        end
        ST_OFFDW: begin
          if (step_hit_w) state_q <= ST_WAIT;
        end
        default: begin
          if (match_w) begin
            done_q  <= 1'b1;
            idx_q   <= '0;
            state_q <= ST_IDLE;
          end else if (timeout_w) begin
            err_q   <= 1'b1;
            idx_q   <= '0;
            state_q <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign clamp_o = clamp_q;
  assign busy_o  = !idle_w;
  assign done_o  = done_q;
  assign err_o   = err_q;

endmodule

// File: rtl/pcs_clamp_seq_chk.sv
module pcs_clamp_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_i,
  input logic       dis_i,
  input logic       tick_i,
  input logic [7:0] rb_i,
  input logic [7:0] clamp_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o,
  input logic       timeout_w
);

  // R2
  clamp_only_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && clamp_o != 8'hFF && !$stable(clamp_o))
      |-> ((clamp_o & ~$past(clamp_o)) == 8'h00));

  // R3
  code_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_o) && !$stable(clamp_o)) |-> $past(tick_i));

  // R4
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R5
  enable_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && en_i && rb_i == 8'h00) |=> (done_o && !busy_o && $stable(clamp_o)));

  // R6
  disable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !en_i && dis_i && rb_i != 8'hFF) |=> (busy_o && clamp_o == 8'hFF));

  // R7
  disable_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !en_i && dis_i && rb_i == 8'hFF) |=> (done_o && !busy_o && $stable(clamp_o)));

  // R8
  enable_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && en_i && dis_i && rb_i != 8'h00) |=> (busy_o && clamp_o == 8'hFE));

  // R9
  timeout_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_w |=> (err_o && !busy_o && !done_o && $stable(clamp_o)));

endmodule

bind pwr_clamp_seq pcs_clamp_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_i      (en_req_i),
  .dis_i     (dis_req_i),
  .tick_i    (tick_i),
  .rb_i      (rb_i),
  .clamp_o   (clamp_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .timeout_w (timeout_w)
);

// File: tb/pwr_clamp_seq_tb.sv
module pwr_clamp_seq_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_req = 1'b0;
  logic dis_req = 1'b0;
  logic [1:0] tdiv = 2'd0;
  logic stuck = 1'b0;
  logic [7:0] stuck_val = 8'h55;
  logic [2:0][7:0] pipe;
  logic [2:0][7:0] pipe5;
  logic tick;
  logic [7:0] rb, rb5, clamp, clamp5;
  logic busy, done, err, busy5, done5, err5;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;
  always @(negedge clk) tdiv <= tdiv + 2'd1;
  assign tick = (tdiv == 2'd0);

  // readback model: follows the clamp word three cycles late
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe  <= {3{8'hFF}};
      pipe5 <= {3{8'hFF}};
    end else begin
      pipe  <= {pipe[1:0], clamp};
      pipe5 <= {pipe5[1:0], clamp5};
    end
  end
  assign rb  = stuck ? stuck_val : pipe[2];
  assign rb5 = stuck ? stuck_val : pipe5[2];

  pwr_clamp_seq u_dut (
    .clk(clk), .rst_n(rst_n), .en_req_i(en_req), .dis_req_i(dis_req),
    .tick_i(tick), .rb_i(rb), .clamp_o(clamp), .busy_o(busy),
    .done_o(done), .err_o(err)
  );

  pwr_clamp_seq #(.USE_MID_STEP(1'b0)) u_dut5 (
    .clk(clk), .rst_n(rst_n), .en_req_i(en_req), .dis_req_i(dis_req),
    .tick_i(tick), .rb_i(rb5), .clamp_o(clamp5), .busy_o(busy5),
    .done_o(done5), .err_o(err5)
  );

  function automatic logic [7:0] exp_code(input int i, input bit mid);
    logic [7:0] full [6] = '{8'hFE, 8'hF8, 8'hE0, 8'hC0, 8'h80, 8'h00};
    logic [7:0] part [5] = '{8'hFE, 8'hF8, 8'hE0, 8'h80, 8'h00};
    return mid ? full[i] : part[i];
  endfunction

  function automatic int exp_dwell(input int i);
    return (i == 0) ? 20 : 10;
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic do_op(input bit en, input bit dis, input bit inject,
                       input bit stall, input bit check5);
    logic [7:0] c0;
    logic [7:0] seq [8];
    int dw [8];
    logic [7:0] s5 [8];
    logic [7:0] last, last5;
    int n, n5, tc;
    bit skip;
    c0 = clamp;
    skip = (en && rb == 8'h00) || (!en && dis && rb == 8'hFF);
    en_req = en;
    dis_req = dis;
    step();
    en_req = 1'b0;
    dis_req = 1'b0;
    if (skip) begin
      chk(en ? "R5 skip done" : "R7 skip done", done, 1);
      chk(en ? "R5 skip not busy" : "R7 skip not busy", busy, 0);
      chk(en ? "R5 no write" : "R7 no write", clamp, c0);
      chk("R9 err cleared by accept", err, 0);
      step();
      chk("R4 done single cycle", done, 0);
      return;
    end
    chk("R9 err cleared by accept", err, 0);
    chk("R4 busy after accept", busy, 1);
    chk(en ? (dis ? "R8 enable wins" : "R2 first code") : "R6 open write",
        clamp, en ? 8'hFE : 8'hFF);
    seq[0] = clamp; n = 1; tc = 0; last = clamp;
    s5[0] = clamp5; n5 = 1; last5 = clamp5;
    for (int k = 0; k < 5000; k++) begin
      step();
      en_req = 1'b0;
      dis_req = 1'b0;
      if (tick) tc++;
      if (clamp != last) begin
        if (n < 8) begin
          dw[n-1] = tc;
          seq[n] = clamp;
        end
        n++;
        tc = 0;
        last = clamp;
      end
      if (clamp5 != last5) begin
        if (n5 < 8) s5[n5] = clamp5;
        n5++;
        last5 = clamp5;
      end
      if (done || err) break;
      if (inject && busy && $urandom_range(0, 7) == 0) begin
        en_req = ($urandom_range(0, 1) == 1);
        dis_req = !en_req;
      end
    end
    if (stall) begin
      chk("R9 error raised", err, 1);
      chk("R9 no done on timeout", done, 0);
      chk("R9 busy drops", busy, 0);
      chk("R9 timeout tick count", tc, 120);
      chk("R9 clamp holds", clamp, 8'h00);
      step();
      chk("R9 err stays high", err, 1);
    end else begin
      chk(en ? "R4 done" : "R6 done", done, 1);
      chk("R4 busy low at done", busy, 0);
      chk("R9 no error", err, 0);
      if (en) begin
        chk("R2 code count", n, 6);
        for (int i = 0; i < 6; i++) chk("R2 code order", seq[i], exp_code(i, 1'b1));
        for (int i = 0; i < 5; i++) chk("R3 dwell ticks", dw[i], exp_dwell(i));
        chk("R4 final dwell ticks", tc, 20);
      end else begin
        chk("R6 single write", n, 1);
        chk("R6 open dwell ticks", tc, 30);
      end
      step();
      chk("R4 done single cycle", done, 0);
    end
    if (check5) begin
      chk("R10 code count", n5, 5);
      for (int i = 0; i < 5; i++) chk("R10 code order", s5[i], exp_code(i, 1'b0));
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c1a3));
    repeat (3) step();
    chk("R1 reset clamp", clamp, 8'hFF);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset err", err, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();
    chk("R1 clamp after reset", clamp, 8'hFF);
    chk("R1 idle after reset", busy, 0);

    do_op(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);   // R7 already open
    do_op(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);   // R2 R3 R4 R10
    do_op(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);   // R5 already closed
    do_op(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);   // R6
    do_op(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);   // R8 both, with injections
    do_op(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);   // R8 injections during open
    stuck = 1'b1;
    do_op(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);   // R9 timeout
    stuck = 1'b0;
    repeat (6) step();
    chk("R9 err held while idle", err, 1);
    do_op(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);   // R9 cleared on accept

    for (int r = 0; r < 30; r++) begin
      int kind;
      kind = $urandom_range(0, 2);
      repeat ($urandom_range(0, 5)) step();
      do_op(kind != 1, kind != 0, $urandom_range(0, 1) == 1, 1'b0, 1'b0);
    end

    summary();
    $finish;
  end

endmodule